// File: doc/BRIEF.md
# Discrete Input Sense Register Target

This block is the serial register front end of a 32-input discrete voltage sensing device. A host reaches it over a four-wire SPI link in mode 0, with the clock idling low, data sampled on rising edges and changed on falling edges. Every transaction begins with a command byte. Its top bit gives the direction and its lower seven bits name a register. On a write the data bytes follow. On a read the block shifts register contents out, most significant byte first.

The register file holds a small control word with a test enable and a soft-reset bit, one sense-mode select bit per bank of eight inputs, and a 16-bit threshold/hysteresis word for each of the two sensing modes (ground-open and supply-open). The comparators sit outside the block, and the 32 input states come in on a parallel port. They can be read one bank per byte, or all 32 at once through a burst alias. Both forms take a snapshot when the command byte completes, so a multi-byte read cannot mix two samples. The block runs on a system clock and oversamples the SPI pins through a two-stage synchronizer.

Top module: `sense_spi_target`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6..0 carry the register address.
- R2: MOSI is captured on rising SCLK edges and MISO changes after falling SCLK edges. Multi-byte values travel most significant byte first. MISO is 0 while chip select is high.
- R3: A read of address 0x78 returns all inputs in four bytes. The first byte carries inputs 31..24, the last carries inputs 7..0, and within the 32-bit value bit n is input n.
- R4: Addresses 0x10, 0x12, 0x14 and 0x16 each return one byte of input states: inputs 7..0, 15..8, 23..16 and 31..24 respectively.
- R5: Input states are sampled once, when the command byte of a read completes. Input changes after that point do not alter the bytes of that transaction.
- R6: Address 0x02 is the control register. Bit 0 is the test enable and bit 1 is the soft reset. Both are written with a one-byte write and read back as one byte, with bits 7..2 reading 0. Reset value is 0x00.
- R7: Address 0x04 holds the sense-mode select. Bit b selects the mode of bank b, which is inputs 8b..8b+7. Bits 7..4 read 0. Reset value is 0x00.
- R8: Address 0x3A (ground-open) and address 0x3C (supply-open) are 16-bit threshold words. Each is written by a command byte followed by the high byte and then the low byte, and read back as two bytes. Reset value of both is 0x0206.
- R9: Raising chip select before a transaction completes discards it: a threshold write that carries only one data byte leaves the word unchanged.
- R10: Reads of unmapped addresses return 0x00. Writes to them change no register.
- R11: While control bit 1 is set, the sense select reads 0x00 and both threshold words read 0x0206, and writes to them are ignored. After bit 1 is written back to 0, those registers accept writes again.
- R12: Bytes read past a register's width return 0x00. Data bytes written past a register's width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| inState | input | 32 | Parallel comparator outputs, bit n is input n |

## Verification
The burst snapshot can coincide with a change on the parallel input port: the command byte of a read may complete in the same cycle that the comparator outputs move. The bench provokes this by starting a burst read of address 0x78 and switching the input pattern immediately after the command byte. It judges the result by requiring that all four returned bytes carry the old pattern. A second overlap pits soft-reset hold against a write to a held register. The bench sends that write while the reset bit is set and expects the register to read its reset value afterwards.

// File: rtl/sense_spi_pkg.sv
package sense_spi_pkg;

  localparam int ADDR_W = 7;
  localparam int WORD_W = 16;
  localparam int SHIFT_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL        = 7'h02;
  localparam logic [ADDR_W-1:0] ADDR_SENSE       = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_STATUS_BASE = 7'h10;
  localparam logic [ADDR_W-1:0] ADDR_THR_GND     = 7'h3A;
  localparam logic [ADDR_W-1:0] ADDR_THR_SUP     = 7'h3C;
  localparam logic [ADDR_W-1:0] ADDR_BURST       = 7'h78;

  localparam logic [WORD_W-1:0] THR_DEFAULT = 16'h0206;

  // strobes from the serial control to the register datapath
  typedef struct packed {
    logic              csIdle;
    logic              loadRd;
    logic              wrEn;
    logic              shiftTx;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } strobe_t;

  function automatic logic isWordReg(input logic [ADDR_W-1:0] a);
    return (a == ADDR_THR_GND) || (a == ADDR_THR_SUP);
  endfunction

  function automatic logic isWritable(input logic [ADDR_W-1:0] a);
    return (a == ADDR_CTRL) || (a == ADDR_SENSE) || isWordReg(a);
  endfunction

endpackage

// File: rtl/sense_spi_ctrl.sv
module sense_spi_ctrl
  import sense_spi_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    mosi,
  output strobe_t st
);

  logic [2:0] syncA, syncB;
  logic       sclkPrev;
  logic       csS, sclkS, mosiS;
  logic       rise, fall;
  logic [2:0] bitCnt;
  logic [1:0] byteIdx;
  logic [6:0] rxShift;
  logic [7:0] rxByte;
  logic       cmdRead;
  logic [ADDR_W-1:0] addrReg;
  logic [7:0] hiByte;

  assign csS    = syncB[2];
  assign sclkS  = syncB[1];
  assign mosiS  = syncB[0];
  assign rise   = sclkS & ~sclkPrev & ~csS;
  assign fall   = ~sclkS & sclkPrev & ~csS;
  assign rxByte = {rxShift, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 3'b100;
      syncB    <= 3'b100;
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      byteIdx  <= '0;
      rxShift  <= '0;
      cmdRead  <= 1'b0;
      addrReg  <= '0;
      hiByte   <= '0;
      st       <= '{csIdle: 1'b1, default: '0};
    end else begin
      syncA      <= {csN, sclk, mosi};
      syncB      <= syncA;
      sclkPrev   <= sclkS;
      st.loadRd  <= 1'b0;
      st.wrEn    <= 1'b0;
      st.shiftTx <= fall;
      st.csIdle  <= csS;
      if (csS) begin
        bitCnt  <= '0;
        byteIdx <= '0;
        rxShift <= '0;
      end else if (rise) begin
        rxShift <= rxByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (byteIdx != 2'd3) byteIdx <= byteIdx + 2'd1;
          case (byteIdx)
            2'd0: begin
              cmdRead <= rxByte[7];
              addrReg <= rxByte[6:0];
              if (rxByte[7]) begin
                st.loadRd <= 1'b1;
                st.addr   <= rxByte[6:0];
              end
            end
            2'd1: begin
              if (!cmdRead) begin
                if (isWordReg(addrReg)) begin
                  hiByte <= rxByte;
                end else begin
                  st.wrEn  <= 1'b1;
                  st.addr  <= addrReg;
                  st.wdata <= {8'h00, rxByte};
                end
              end
            end
            2'd2: begin
              if (!cmdRead && isWordReg(addrReg)) begin
                st.wrEn  <= 1'b1;
                st.addr  <= addrReg;
                st.wdata <= {hiByte, rxByte};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.loadRd, st.wrEn, st.shiftTx})); // R1

  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !st.wrEn); // R9

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && byteIdx != 2'd0) |-> !st.wrEn); // R1

endmodule

// File: rtl/sense_spi_regs.sv
module sense_spi_regs
  import sense_spi_pkg::*;
#(
  parameter int NUM_INPUTS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic [NUM_INPUTS-1:0] inState,
  output logic                  miso
);

  localparam int NUM_BANKS = NUM_INPUTS / 8;

  logic [1:0]           ctrlReg;
  logic [NUM_BANKS-1:0] senseSel;
  logic [WORD_W-1:0]    thrGnd, thrSup;
  logic [SHIFT_W-1:0]   statusWide;
  logic [SHIFT_W-1:0]   rdValue;
  logic [SHIFT_W-1:0]   txShift;
  logic                 misoReg;
  logic [7:0]           statusByte [NUM_BANKS];

  always_comb begin
    statusWide = '0;
    statusWide[NUM_INPUTS-1:0] = inState;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign statusByte[b] = statusWide[8*b +: 8];
  end

  // register file with self-held soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      senseSel <= '0;
      thrGnd   <= THR_DEFAULT;
      thrSup   <= THR_DEFAULT;
    end else begin
      if (st.wrEn && st.addr == ADDR_CTRL) ctrlReg <= st.wdata[1:0];
      if (ctrlReg[1]) begin
        senseSel <= '0;
        thrGnd   <= THR_DEFAULT;
        thrSup   <= THR_DEFAULT;
      end else if (st.wrEn) begin
        case (st.addr)
          ADDR_SENSE:   senseSel <= st.wdata[NUM_BANKS-1:0];
          ADDR_THR_GND: thrGnd   <= st.wdata;
          ADDR_THR_SUP: thrSup   <= st.wdata;
          default: ;
        endcase
      end
    end
  end

  // read value, left aligned for MSB-first shifting
  always_comb begin
    rdValue = '0;
    case (st.addr)
      ADDR_CTRL:    rdValue[31:24] = {6'b0, ctrlReg};
      ADDR_SENSE:   rdValue[31:24] = 8'(senseSel);
      ADDR_THR_GND: rdValue[31:16] = thrGnd;
      ADDR_THR_SUP: rdValue[31:16] = thrSup;
      ADDR_BURST:   rdValue = statusWide;
      default: ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (st.addr == ADDR_STATUS_BASE + 7'(2 * b)) rdValue[31:24] = statusByte[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (st.csIdle) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (st.loadRd) begin
      txShift <= rdValue;
    end else if (st.shiftTx) begin
      misoReg <= txShift[SHIFT_W-1];
      txShift <= {txShift[SHIFT_W-2:0], 1'b0};
    end
  end

  assign miso = misoReg;

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    st.csIdle |=> !miso); // R2

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[1] |=> (senseSel == '0 && thrGnd == THR_DEFAULT && thrSup == THR_DEFAULT)); // R11

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && !isWritable(st.addr) && !ctrlReg[1]) |=>
      ($stable(ctrlReg) && $stable(senseSel) && $stable(thrGnd) && $stable(thrSup))); // R10

  AST_BURST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadRd && !st.csIdle && st.addr == ADDR_BURST) |=> (txShift == $past(statusWide))); // R5

endmodule

// File: rtl/sense_spi_target.sv
module sense_spi_target
  import sense_spi_pkg::*;
#(
  parameter int NUM_INPUTS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [NUM_INPUTS-1:0] inState
);

  strobe_t st;

  sense_spi_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sclk (sclk),
    .csN  (csN),
    .mosi (mosi),
    .st   (st)
  );

  sense_spi_regs #(.NUM_INPUTS(NUM_INPUTS)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .inState (inState),
    .miso    (miso)
  );

endmodule

// File: tb/tb_sense_spi_target.sv
module tb_sense_spi_target;

  localparam time HALF = 40ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [31:0] inState = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  sense_spi_target dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso), .inState(inState)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic spiBegin();
    csN = 1'b0;
    #HALF;
  endtask

  task automatic spiEnd();
    #HALF;
    csN = 1'b1;
    #(4 * HALF);
  endtask

  task automatic spiByte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      #HALF;
      r[i] = miso;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic rdReg(input logic [6:0] a, input int n, output logic [31:0] v);
    logic [7:0] r;
    v = '0;
    spiBegin();
    spiByte({1'b1, a}, r);
    for (int k = 0; k < n; k++) begin
      spiByte(8'h00, r);
      v = {v[23:0], r};
    end
    spiEnd();
  endtask

  task automatic wrReg(input logic [6:0] a, input int n, input logic [23:0] d);
    logic [7:0] r;
    spiBegin();
    spiByte({1'b0, a}, r);
    for (int k = n - 1; k >= 0; k--) spiByte(d[8*k +: 8], r);
    spiEnd();
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R2 miso idle", {31'b0, miso}, 32'h0);
    rdReg(7'h02, 1, v); check("R6 ctrl reset", v, 32'h00);
    rdReg(7'h04, 1, v); check("R7 sense reset", v, 32'h00);
    rdReg(7'h3A, 2, v); check("R8 gnd thr reset", v, 32'h0206);
    rdReg(7'h3C, 2, v); check("R8 sup thr reset", v, 32'h0206);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    inState = 32'hA1B2C3D4;
    rdReg(7'h78, 4, v); check("R3 burst", v, 32'hA1B2C3D4);
    rdReg(7'h10, 1, v); check("R4 bank0", v, 32'hD4);
    rdReg(7'h12, 1, v); check("R4 bank1", v, 32'hC3);
    rdReg(7'h14, 1, v); check("R4 bank2", v, 32'hB2);
    rdReg(7'h16, 1, v); check("R4 bank3", v, 32'hA1);
    inState = 32'h0000_8001;
    rdReg(7'h78, 4, v); check("R3 burst single bits", v, 32'h0000_8001);
  endtask

  task automatic testSnapshot();
    logic [7:0] r;
    logic [31:0] v;
    inState = 32'h1234_5678;
    v = '0;
    spiBegin();
    spiByte(8'hF8, r);
    inState = 32'hFFFF_0000;
    for (int k = 0; k < 4; k++) begin
      spiByte(8'h00, r);
      v = {v[23:0], r};
      inState = ~inState;
    end
    spiEnd();
    check("R5 coherent burst", v, 32'h1234_5678);
  endtask

  task automatic testCtrlSense();
    logic [31:0] v;
    wrReg(7'h02, 1, 24'h01);
    rdReg(7'h02, 1, v); check("R1 R6 ctrl test bit", v, 32'h01);
    rdReg(7'h02, 3, v); check("R12 read past width", v, 32'h010000);
    wrReg(7'h04, 1, 24'hFF);
    rdReg(7'h04, 1, v); check("R7 sense upper bits zero", v, 32'h0F);
    wrReg(7'h04, 2, 24'h030C);
    rdReg(7'h04, 1, v); check("R12 extra write byte ignored", v, 32'h03);
  endtask

  task automatic testThresholds();
    logic [7:0] r;
    logic [31:0] v;
    wrReg(7'h3A, 2, 24'h1234);
    wrReg(7'h3C, 2, 24'h0A0B);
    rdReg(7'h3A, 2, v); check("R8 gnd word", v, 32'h1234);
    rdReg(7'h3C, 2, v); check("R8 sup word", v, 32'h0A0B);
    spiBegin();
    spiByte(8'h3C, r);
    spiByte(8'h99, r);
    spiEnd();
    rdReg(7'h3C, 2, v); check("R9 partial write dropped", v, 32'h0A0B);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    rdReg(7'h05, 1, v); check("R10 unmapped read", v, 32'h00);
    rdReg(7'h11, 1, v); check("R10 unmapped odd status", v, 32'h00);
    wrReg(7'h05, 1, 24'h55);
    wrReg(7'h3B, 2, 24'hBEEF);
    rdReg(7'h04, 1, v); check("R10 sense after unmapped write", v, 32'h03);
    rdReg(7'h3A, 2, v); check("R10 gnd after unmapped write", v, 32'h1234);
    rdReg(7'h02, 1, v); check("R10 ctrl after unmapped write", v, 32'h01);
  endtask

  task automatic testSoftReset();
    logic [31:0] v;
    wrReg(7'h02, 1, 24'h02);
    rdReg(7'h02, 1, v); check("R11 ctrl shows reset bit", v, 32'h02);
    rdReg(7'h04, 1, v); check("R11 sense held", v, 32'h00);
    rdReg(7'h3A, 2, v); check("R11 gnd held", v, 32'h0206);
    wrReg(7'h04, 1, 24'h05);
    wrReg(7'h3C, 2, 24'h4444);
    rdReg(7'h04, 1, v); check("R11 sense write ignored", v, 32'h00);
    rdReg(7'h3C, 2, v); check("R11 sup write ignored", v, 32'h0206);
    wrReg(7'h02, 1, 24'h00);
    wrReg(7'h04, 1, 24'h05);
    rdReg(7'h04, 1, v); check("R11 sense after release", v, 32'h05);
    check("R2 miso idle after traffic", {31'b0, miso}, 32'h0);
  endtask

  initial begin
    #900us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (10) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testStatus();
    testSnapshot();
    testCtrlSense();
    testThresholds();
    testUnmapped();
    testSoftReset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule